// File: doc/BRIEF.md
# Nested zero-overhead loop controller

This block is the loop unit of a 32-bit in-order processor. It keeps two loop contexts. Each context holds a first-instruction address, an exit address and a remaining-iteration count. The exit address is the address of the first instruction after the body, so the final body instruction sits at the exit address minus 4. The unit watches every retiring instruction. When the final body instruction of an active loop retires, it decrements that loop's count. If more passes remain, it drives a redirect to the loop's first instruction in the same cycle, so the next fetch pays no stall cycles.

Context 0 is the inner loop and context 1 is the outer loop. When both would react to the same retirement, context 0 wins. Software loads the fields through a setup port. All six registers can be read through a read-only CSR-style port. A write attempt on that port only raises an illegal-instruction flag. The unit never checks whether software broke the loop rules. Short bodies, badly ordered exit addresses and branches inside a body give whatever behaviour falls out of the rules below.

Top module: `zol_unit`

## Requirements
- R1: After reset, all six loop registers read 0, no loop is active and redirect_o stays low.
- R2: A setup write with field code 0 (first-instruction address) or code 1 (exit address) stores setup_val_i with bits 1:0 cleared. The new value can be read from the next cycle on.
- R3: A setup write with field code 2 (count) stores setup_val_i unchanged. The new value can be read from the next cycle on. Field code 3 changes nothing.
- R4: A loop is active while its count is nonzero. When retire_valid_i is high and retire_pc_i matches an active loop's exit address minus 4 (retire_pc_i bits 1:0 ignored) and the count is above 1, redirect_o is high in the same cycle and redirect_pc_o equals that loop's first-instruction address. The count is one lower on the next cycle.
- R5: A retirement at any address other than an active loop's final body instruction gives no redirect and leaves every count unchanged.
- R6: When the final body instruction retires with a count of 1, redirect_o stays low and the count becomes 0, so execution falls through to the exit address.
- R7: A loop whose count is 0 never causes a redirect and its count stays 0 until a setup write.
- R8: When both loops match the same retirement, only loop 0 is serviced: the redirect goes to loop 0's first instruction and loop 1's count is unchanged.
- R9: A count setup write in the same cycle as a decrement of that loop wins. The next cycle holds the written value. That cycle's redirect still follows the count from before the write.
- R10: csr_we_i drives illegal_o high in the same cycle and changes no register.
- R11: With retire_valid_i low, retire_pc_i has no effect: there is no redirect and no count changes.
- R12: csr_sel_i bit 0 selects the loop and bits 2:1 hold the field code (0 first address, 1 exit address, 2 count). csr_rdata_o shows the selected register in the same cycle. Field code 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_pc_i | input | 32 | Address of the retiring instruction |
| setup_we_i | input | 1 | Setup write strobe |
| setup_idx_i | input | 1 | Loop index for the setup write |
| setup_fld_i | input | 2 | Field code: 0 first address, 1 exit address, 2 count |
| setup_val_i | input | 32 | Value to write |
| csr_sel_i | input | 3 | Read select: bit 0 loop, bits 2:1 field code |
| csr_we_i | input | 1 | CSR write attempt on the read-only view |
| csr_rdata_o | output | 32 | Selected register value |
| illegal_o | output | 1 | Illegal-instruction flag for a CSR write attempt |
| redirect_o | output | 1 | Fetch must go to redirect_pc_o next |
| redirect_pc_o | output | 32 | Redirect target address |

## Verification
The main function is run as a retired-instruction stream from a two-level nested program, in which the bench follows the redirects it predicts and reloads the inner count at the top of the outer body. This shows that redirects happen on the final body instruction only and that both loops fall through at the end. Hand-built single retirements separate the cases: two loops sharing one exit address (priority), a count of 1 (fall-through), a count of 0 (inactive), a count write colliding with a decrement, and a retirement with valid low. A long pseudo-random phase then mixes addresses around both bodies, unaligned setup values, CSR write attempts and every read select. This exposes any mismatch in masking, priority or update order against the behavioural model.

// File: rtl/zol_pkg.sv
`timescale 1ns/1ps
package zol_pkg;

    localparam int unsigned AW = 32;
    localparam int unsigned CW = 32;

    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_EXIT  = 2'd1,
        FLD_COUNT = 2'd2,
        FLD_NONE  = 2'd3
    } field_e;

    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] fin;
        logic [CW-1:0] cnt;
    } loop_set_t;

endpackage

// File: rtl/zol_match.sv
`timescale 1ns/1ps
module zol_match
    import zol_pkg::*;
(
    input  logic          valid_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] fin_i,
    input  logic [CW-1:0] cnt_i,
    output logic          hit_o,
    output logic          final_o
);

    localparam logic [AW-3:0] ONE_WORD = 1;

    logic [AW-3:0] last_word;
    logic          unused_pc_lo;

    assign unused_pc_lo = ^pc_i[1:0];

    always_comb begin
        last_word = fin_i[AW-1:2] - ONE_WORD;
        hit_o     = valid_i && (cnt_i != '0) && (pc_i[AW-1:2] == last_word);
        final_o   = (cnt_i == CW'(1));
    end

endmodule

// File: rtl/zol_prio.sv
`timescale 1ns/1ps
module zol_prio #(
    parameter  int unsigned N  = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        gnt_o = '0;
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                gnt_o[i] = 1'b1;
                any_o    = 1'b1;
                idx_o    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/zol_csr_view.sv
`timescale 1ns/1ps
module zol_csr_view
    import zol_pkg::*;
#(
    parameter  int unsigned N  = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned SW = IW + 2
) (
    input  loop_set_t [N-1:0] sets_i,
    input  logic [SW-1:0]     sel_i,
    output logic [31:0]       rdata_o
);

    logic [IW-1:0] lidx;
    field_e        fld;
    loop_set_t     cur;
    logic          found;

    always_comb begin
        lidx  = sel_i[IW-1:0];
        fld   = field_e'(sel_i[SW-1:IW]);
        cur   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (lidx == IW'(i)) begin
                cur   = sets_i[i];
                found = 1'b1;
            end
        end
        rdata_o = '0;
        if (found) begin
            case (fld)
                FLD_START: rdata_o = cur.start;
                FLD_EXIT:  rdata_o = cur.fin;
                FLD_COUNT: rdata_o = cur.cnt;
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/zol_unit.sv
`timescale 1ns/1ps
module zol_unit
    import zol_pkg::*;
#(
    parameter  int unsigned NUM_LOOPS = 2,
    localparam int unsigned IDX_W     = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1,
    localparam int unsigned SEL_W     = IDX_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             retire_valid_i,
    input  logic [AW-1:0]    retire_pc_i,
    input  logic             setup_we_i,
    input  logic [IDX_W-1:0] setup_idx_i,
    input  logic [1:0]       setup_fld_i,
    input  logic [31:0]      setup_val_i,
    input  logic [SEL_W-1:0] csr_sel_i,
    input  logic             csr_we_i,
    output logic [31:0]      csr_rdata_o,
    output logic             illegal_o,
    output logic             redirect_o,
    output logic [AW-1:0]    redirect_pc_o
);

    typedef struct packed {
        loop_set_t [NUM_LOOPS-1:0] loops;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LOOPS-1:0] hit;
    logic [NUM_LOOPS-1:0] last_iter;
    logic [NUM_LOOPS-1:0] gnt;
    logic                 any_hit;
    logic [IDX_W-1:0]     win_idx;
    loop_set_t            win;
    field_e               fld;

    // per-loop exit comparators
    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_match
        zol_match u_match (
            .valid_i (retire_valid_i),
            .pc_i    (retire_pc_i),
            .fin_i   (st_q.loops[g].fin),
            .cnt_i   (st_q.loops[g].cnt),
            .hit_o   (hit[g]),
            .final_o (last_iter[g])
        );
    end

    // lowest index (innermost) loop wins
    zol_prio #(.N(NUM_LOOPS)) u_prio (
        .req_i (hit),
        .gnt_o (gnt),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    zol_csr_view #(.N(NUM_LOOPS)) u_view (
        .sets_i  (st_q.loops),
        .sel_i   (csr_sel_i),
        .rdata_o (csr_rdata_o)
    );

    always_comb begin
        st_d = st_q;
        fld  = field_e'(setup_fld_i);
        win  = '0;
        for (int k = 0; k < NUM_LOOPS; k++) begin
            if (win_idx == IDX_W'(k)) begin
                win = st_q.loops[k];
            end
        end

        // zero-stall redirect from the pre-update state
        redirect_o    = any_hit && ((gnt & last_iter) == '0);
        redirect_pc_o = redirect_o ? win.start : '0;

        for (int k = 0; k < NUM_LOOPS; k++) begin
            if (gnt[k]) begin
                st_d.loops[k].cnt = st_q.loops[k].cnt - CW'(1);
            end
            // setup write overrides the decrement
            if (setup_we_i && (setup_idx_i == IDX_W'(k))) begin
                case (fld)
                    FLD_START: st_d.loops[k].start = {setup_val_i[AW-1:2], 2'b00};
                    FLD_EXIT:  st_d.loops[k].fin   = {setup_val_i[AW-1:2], 2'b00};
                    FLD_COUNT: st_d.loops[k].cnt   = setup_val_i[CW-1:0];
                    default:   ;
                endcase
            end
        end

        illegal_o = csr_we_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zol_unit_chk.sv
`timescale 1ns/1ps
module zol_unit_chk
    import zol_pkg::*;
#(
    parameter  int unsigned N  = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             retire_valid_i,
    input logic [AW-1:0]    retire_pc_i,
    input logic             setup_we_i,
    input logic [IW-1:0]    setup_idx_i,
    input logic [1:0]       setup_fld_i,
    input logic [31:0]      setup_val_i,
    input logic             csr_we_i,
    input logic             redirect_i,
    input logic [AW-1:0]    redirect_pc_i,
    input loop_set_t [N-1:0] loops_i
);

    logic [CW-1:0] cnt0, cnt1;
    logic          wr_cnt0, wr_cnt1, hit0;
    logic          unused_chk;

    assign cnt0       = loops_i[0].cnt;
    assign cnt1       = loops_i[1].cnt;
    assign wr_cnt0    = setup_we_i && (setup_idx_i == IW'(0)) && (setup_fld_i == 2'd2);
    assign wr_cnt1    = setup_we_i && (setup_idx_i == IW'(1)) && (setup_fld_i == 2'd2);
    assign hit0       = retire_valid_i && (cnt0 != '0) &&
                        ((retire_pc_i[AW-1:2] + 1'b1) == loops_i[0].fin[AW-1:2]);
    assign unused_chk = ^{retire_pc_i[1:0], redirect_pc_i, loops_i};

    p_redirect_from_retire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_i |-> retire_valid_i);

    p_target_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_i |-> (redirect_pc_i[1:0] == 2'b00));

    p_count_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_cnt0 |=> ((cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) - 1)));

    p_inactive_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt0 == '0) && !wr_cnt0) |=> (cnt0 == '0));

    p_idle_no_redirect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt0 == '0) && (cnt1 == '0)) |-> !redirect_i);

    p_inner_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit0 && !wr_cnt1) |=> (cnt1 == $past(cnt1)));

    p_final_falls_through_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit0 && (cnt0 == CW'(1))) |-> !redirect_i);

    p_setup_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt0 |=> (cnt0 == $past(setup_val_i[CW-1:0])));

    p_csr_write_inert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && !setup_we_i && !retire_valid_i) |=> $stable(loops_i));

endmodule

bind zol_unit zol_unit_chk #(.N(NUM_LOOPS)) u_zol_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_valid_i (retire_valid_i),
    .retire_pc_i    (retire_pc_i),
    .setup_we_i     (setup_we_i),
    .setup_idx_i    (setup_idx_i),
    .setup_fld_i    (setup_fld_i),
    .setup_val_i    (setup_val_i),
    .csr_we_i       (csr_we_i),
    .redirect_i     (redirect_o),
    .redirect_pc_i  (redirect_pc_o),
    .loops_i        (st_q.loops)
);

// File: tb/zol_unit_test.sv
`timescale 1ns/1ps
module zol_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv = 1'b0;
    logic [31:0] pc = '0;
    logic        swe = 1'b0;
    logic [0:0]  sidx = '0;
    logic [1:0]  sfld = '0;
    logic [31:0] sval = '0;
    logic [2:0]  csel = '0;
    logic        cwe = 1'b0;
    logic [31:0] rdata;
    logic        illegal;
    logic        redirect;
    logic [31:0] redirect_pc;

    always #4 clk = ~clk;

    zol_unit uut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .retire_valid_i (rv),
        .retire_pc_i    (pc),
        .setup_we_i     (swe),
        .setup_idx_i    (sidx),
        .setup_fld_i    (sfld),
        .setup_val_i    (sval),
        .csr_sel_i      (csel),
        .csr_we_i       (cwe),
        .csr_rdata_o    (rdata),
        .illegal_o      (illegal),
        .redirect_o     (redirect),
        .redirect_pc_o  (redirect_pc)
    );

    int          total = 0;
    int          bad = 0;
    string       tag = "R1";
    logic [31:0] m_start [2];
    logic [31:0] m_end   [2];
    logic [31:0] m_cnt   [2];
    logic        pred_redir;
    logic [31:0] pred_pc;
    logic [31:0] lfsr = 32'h1BADF00D;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] sel);
        int l = int'(sel[0]);
        case (sel[2:1])
            2'd0: return m_start[l];
            2'd1: return m_end[l];
            2'd2: return m_cnt[l];
            default: return 32'h0;
        endcase
    endfunction

    function automatic int model_pick();
        for (int k = 0; k < 2; k++) begin
            if (rv && (m_cnt[k] != 0) &&
                ((pc >> 2) == (((m_end[k] >> 2) - 1) & 32'h3FFF_FFFF)))
                return k;
        end
        return -1;
    endfunction

    task automatic clear_inputs();
        rv = 1'b0; pc = '0; swe = 1'b0; sidx = '0; sfld = '0; sval = '0; cwe = 1'b0;
    endtask

    // one cycle: compare outputs mid-cycle, then advance the model at the edge
    task automatic step();
        int s;
        #1;
        s = model_pick();
        pred_redir = 1'b0;
        pred_pc = '0;
        if (s >= 0) begin
            if (m_cnt[s] != 1) begin
                pred_redir = 1'b1;
                pred_pc = m_start[s];
            end
        end
        check("redirect", {31'b0, redirect}, {31'b0, pred_redir});
        if (pred_redir) check("redirect_pc", redirect_pc, pred_pc);
        check("illegal", {31'b0, illegal}, {31'b0, cwe});
        check("csr_rdata", rdata, model_read(csel));
        @(posedge clk);
        if (s >= 0) m_cnt[s] = m_cnt[s] - 1;
        if (swe) begin
            case (sfld)
                2'd0: m_start[sidx] = sval & ~32'h3;
                2'd1: m_end[sidx]   = sval & ~32'h3;
                2'd2: m_cnt[sidx]   = sval;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic dump_regs();
        for (int s = 0; s < 8; s++) begin
            clear_inputs();
            csel = 3'(s);
            step();
        end
    endtask

    task automatic setw(input int idx, input int fld, input logic [31:0] val);
        clear_inputs();
        swe = 1'b1; sidx = 1'(idx); sfld = 2'(fld); sval = val;
        step();
        clear_inputs();
    endtask

    task automatic retire(input logic [31:0] addr);
        clear_inputs();
        rv = 1'b1; pc = addr;
        step();
        clear_inputs();
    endtask

    task automatic rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        for (int k = 0; k < 2; k++) begin
            m_start[k] = '0; m_end[k] = '0; m_cnt[k] = '0;
        end
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: registers clear after reset, no redirect
        tag = "R1";
        dump_regs();
        retire(32'hFFFF_FFF8);

        // R2: unaligned setup values are stored with low bits cleared
        tag = "R2";
        setw(0, 0, 32'h0000_0103);
        setw(0, 1, 32'h0000_010E);
        setw(1, 0, 32'h0000_00F1);
        setw(1, 1, 32'h0000_0118);
        dump_regs();
        setw(0, 0, 32'h0000_0100);

        // R3: count writes, and field code 3 changes nothing
        tag = "R3";
        setw(1, 2, 32'd2);
        setw(0, 3, 32'hDEAD_BEEF);
        dump_regs();

        // R4 R5 R6: nested program, inner count reloaded at top of outer body
        tag = "R4";
        begin
            logic [31:0] at = 32'h0F0;
            n = 0;
            while (at != 32'h118 && n < 200) begin
                clear_inputs();
                rv = 1'b1; pc = at;
                if (at == 32'h0F0) begin
                    swe = 1'b1; sidx = 1'b0; sfld = 2'd2; sval = 32'd3;
                end
                step();
                at = pred_redir ? pred_pc : at + 4;
                n++;
            end
            tag = "R6";
            check("retired_count", 32'(n), 32'd32);
            clear_inputs();
            dump_regs();
        end

        // R5: off-end address with active loop
        tag = "R5";
        setw(0, 2, 32'd4);
        retire(32'h0000_0104);
        retire(32'h0000_010C);
        dump_regs();

        // R7: inactive loop at its final body address
        tag = "R7";
        setw(0, 2, 32'd0);
        retire(32'h0000_0108);
        dump_regs();

        // R8: both loops share one exit; loop 0 first
        tag = "R8";
        setw(1, 1, 32'h0000_010C);
        setw(0, 2, 32'd2);
        setw(1, 2, 32'd2);
        retire(32'h0000_0108);
        dump_regs();
        retire(32'h0000_0108);
        dump_regs();
        retire(32'h0000_0108);
        dump_regs();

        // R9: count write collides with a decrement
        tag = "R9";
        setw(0, 2, 32'd5);
        clear_inputs();
        rv = 1'b1; pc = 32'h0000_0108;
        swe = 1'b1; sidx = 1'b0; sfld = 2'd2; sval = 32'd9;
        step();
        dump_regs();

        // R10: CSR write attempt
        tag = "R10";
        clear_inputs();
        cwe = 1'b1; csel = 3'd4;
        step();
        dump_regs();

        // R11: valid low at the final body address
        tag = "R11";
        clear_inputs();
        pc = 32'h0000_0108;
        step();
        dump_regs();

        // R12: every read select, including field code 3
        tag = "R12";
        setw(1, 0, 32'h0000_00F8);
        dump_regs();

        // mixed pseudo-random traffic
        tag = "R4";
        setw(0, 0, 32'h100); setw(0, 1, 32'h10C);
        setw(1, 0, 32'h0F0); setw(1, 1, 32'h118);
        for (int i = 0; i < 3000; i++) begin
            rnd();
            clear_inputs();
            rv   = lfsr[0] | lfsr[1];
            pc   = 32'h0F0 + (lfsr & 32'h3F);
            csel = lfsr[10:8];
            cwe  = (lfsr[14:12] == 3'd0);
            if (lfsr[23:21] == 3'd0) begin
                swe  = 1'b1;
                sidx = lfsr[24];
                sfld = lfsr[26:25];
                sval = (lfsr[26:25] == 2'd2) ? {29'd0, lfsr[29:27]}
                                             : 32'h0F0 + {26'd0, lfsr[31:26]};
            end
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule